// File: doc/BRIEF.md
# Two-Step-Per-Clock SHA-1 Block Compressor

This block folds one 512-bit message block into a 160-bit chaining value using the SHA-1 compression function. It takes a block, the incoming chaining value and a one-cycle start pulse. It produces the new chaining value and a one-cycle done pulse. Message padding and splitting a message into blocks are handled outside the block. To hash a longer message, the caller feeds each new block together with the previous digest.

Inside, two SHA-1 steps are retired in every clock cycle. One set-up cycle first fills three registers with partial sums. These sums cover the round function, the spare state word, the schedule word and the round constant for the next pair of steps. Because they are ready in advance, no more than one round function and two adders sit ahead of each state register. The 16-word message window slides by two words per cycle and extends the schedule as it goes. The 80 steps therefore finish 41 cycles after start.

Top module: `sha1x2_core`

## Requirements
- R1: After reset, `done_o` is 0 and `digest_o` is all zeros.
- R2: Word t of the block for t < 16 is `block_i[511-32t -: 32]`, so word 0 is in the top bits. The chaining words H0..H4 sit in `chain_i[159:128]` down to `chain_i[31:0]`, and `digest_o` uses the same layout. With the standard initial value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0 and the padded one-block message "abc", the digest is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R3: Feeding the digest of one block back as `chain_i` for the next block gives the standard two-block result 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1 for the padded 448-bit test message.
- R4: `done_o` is first seen high 41 clock cycles after the edge that samples the accepted `start_i`.
- R5: `done_o` is high for exactly one cycle per accepted block.
- R6: While a block is in progress, `start_i` is ignored, and so are changes on `block_i` and `chain_i`. The digest and the timing of that block are unchanged, and no extra done pulse follows.
- R7: `digest_o` changes only in the cycle in which `done_o` is high. It holds its value from one completion to the next, including while the next block is in progress.
- R8: For any block and any chaining input, the digest equals the 80-step SHA-1 compression result, with each of the five final words added modulo 2^32 to its chaining word.
- R9: A start raised in the cycle in which `done_o` is high is accepted. Blocks can therefore follow one another every 42 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a block when the core is idle |
| block_i | input | 512 | Message block, word 0 in the top bits |
| chain_i | input | 160 | Incoming chaining value, H0 in the top bits |
| digest_o | output | 160 | Outgoing chaining value |
| done_o | output | 1 | One-cycle pulse when `digest_o` is updated |

## Verification
The standard one-block and two-block vectors catch errors in the round function bands, the constant bands and the order of the schedule words. Any of these would corrupt every word of the digest. Random blocks with random chaining inputs are compared with a plain step-by-step model in the bench. That comparison exposes a preprocessed sum that uses the wrong step's constant or function near a band edge, which a single vector might hide. Start pulses in the middle of a block, one of them on the final step edge, and block data that changes during a run test whether the core can be restarted or can reload its window. Such a fault shows up as a wrong digest, a late done or a second done. Back-to-back starts on the done cycle show whether the return to idle loses a cycle, and the digest is watched across idle and busy cycles for any early update.

// File: rtl/sha1x2_pkg.sv
package sha1x2_pkg;

    localparam int WORD_W      = 32;
    localparam int BLOCK_WORDS = 16;
    localparam int BLOCK_W     = WORD_W * BLOCK_WORDS;
    localparam int STATE_WORDS = 5;
    localparam int STATE_W     = WORD_W * STATE_WORDS;
    localparam int STEPS       = 80;
    localparam int PAIR_CYCLES = STEPS / 2;
    localparam int LATENCY     = PAIR_CYCLES + 1;
    localparam int CNT_W       = $clog2(PAIR_CYCLES);
    localparam int STEP_W      = CNT_W + 1;
    localparam int TAPS        = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } state_t;

    // sums prepared one cycle ahead of the step pair that consumes them
    typedef struct packed {
        word_t l;
        word_t m;
        word_t n;
    } presum_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PREP,
        PH_RUN
    } phase_t;

    function automatic word_t rotl(input word_t x, input int unsigned s);
        return (x << s) | (x >> (WORD_W - s));
    endfunction

    function automatic word_t k_of(input step_t step);
        if (step < STEP_W'(20))      return 32'h5A82_7999;
        else if (step < STEP_W'(40)) return 32'h6ED9_EBA1;
        else if (step < STEP_W'(60)) return 32'h8F1B_BCDC;
        else                         return 32'hCA62_C1D6;
    endfunction

    function automatic word_t f_of(input step_t step, input word_t b,
                                   input word_t c, input word_t d);
        if (step < STEP_W'(20))      return (b & c) | (~b & d);
        else if (step < STEP_W'(40)) return b ^ c ^ d;
        else if (step < STEP_W'(60)) return (b & c) | (b & d) | (c & d);
        else                         return b ^ c ^ d;
    endfunction

endpackage

// File: rtl/sha1x2_sched.sv
module sha1x2_sched
    import sha1x2_pkg::*;
(
    input  logic               clk_i,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [BLOCK_W-1:0] block_i,
    output word_t              tap_o [TAPS]
);

    word_t win_q [BLOCK_WORDS];
    word_t ext_lo;
    word_t ext_hi;

    // the two words that enter at the top of the window, W(t+16) and W(t+17)
    assign ext_lo = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
    assign ext_hi = rotl(win_q[14] ^ win_q[9] ^ win_q[3] ^ win_q[1], 1);

    for (genvar i = 0; i < BLOCK_WORDS; i++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (load_i) begin
                win_q[i] <= block_i[BLOCK_W-1-WORD_W*i -: WORD_W];
            end else if (shift_i) begin
                if (i < BLOCK_WORDS - 2) begin
                    win_q[i] <= win_q[i+2];
                end else if (i == BLOCK_WORDS - 2) begin
                    win_q[i] <= ext_lo;
                end else begin
                    win_q[i] <= ext_hi;
                end
            end
        end
    end

    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        assign tap_o[j] = win_q[j];
    end

endmodule

// File: rtl/sha1x2_ctrl.sv
module sha1x2_ctrl
    import sha1x2_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  start_i,
    output logic  load_o,
    output logic  prep_o,
    output logic  run_o,
    output logic  last_o,
    output step_t step_o
);

    phase_t           phase_q;
    logic [CNT_W-1:0] pair_q;

    assign load_o = (phase_q == PH_IDLE) && start_i;
    assign prep_o = (phase_q == PH_PREP);
    assign run_o  = (phase_q == PH_RUN);
    assign last_o = run_o && (pair_q == CNT_W'(PAIR_CYCLES - 1));
    assign step_o = {pair_q, 1'b0};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            pair_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_i) phase_q <= PH_PREP;
                PH_PREP: begin
                    phase_q <= PH_RUN;
                    pair_q  <= '0;
                end
                PH_RUN: begin
                    pair_q <= pair_q + 1'b1;
                    if (last_o) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sha1x2_prep.sv
module sha1x2_prep
    import sha1x2_pkg::*;
(
    input  word_t   b_i,
    input  word_t   c_i,
    input  word_t   d_i,
    input  word_t   e_i,
    input  word_t   w0_i,
    input  word_t   w1_i,
    input  word_t   w2_i,
    output presum_t sum_o
);

    always_comb begin
        sum_o.l = f_of(STEP_W'(0), b_i, c_i, d_i) + e_i + w0_i + k_of(STEP_W'(0));
        sum_o.m = d_i + w1_i + k_of(STEP_W'(1));
        sum_o.n = w2_i + k_of(STEP_W'(2));
    end

endmodule

// File: rtl/sha1x2_round.sv
module sha1x2_round
    import sha1x2_pkg::*;
(
    input  step_t   step_i,
    input  word_t   a_i,
    input  word_t   b_i,
    input  word_t   c_i,
    input  presum_t sum_i,
    input  word_t   w3_i,
    input  word_t   w4_i,
    output state_t  state_o,
    output presum_t sum_o
);

    word_t mid;

    always_comb begin
        // first step of the pair completes into b'
        mid       = rotl(a_i, 5) + sum_i.l;
        state_o.b = mid;
        state_o.a = rotl(mid, 5) + f_of(step_i, a_i, rotl(b_i, 30), c_i) + sum_i.m;
        state_o.c = rotl(a_i, 30);
        state_o.d = rotl(b_i, 30);
        state_o.e = c_i;
        // sums for the pair that starts at step+2
        sum_o.l = f_of(step_i + step_t'(2), state_o.b, state_o.c, state_o.d)
                  + c_i + sum_i.n;
        sum_o.m = state_o.d + w3_i + k_of(step_i + step_t'(3));
        sum_o.n = w4_i + k_of(step_i + step_t'(4));
    end

endmodule

// File: rtl/sha1x2_core.sv
module sha1x2_core
    import sha1x2_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic [STATE_W-1:0] chain_i,
    output logic [STATE_W-1:0] digest_o,
    output logic               done_o
);

    logic    load, prep, run, last;
    step_t   step;
    word_t   tap [TAPS];
    state_t  st_q, st_nx, hin_q, dig_q;
    presum_t sum_q, sum_prep, sum_nx;

    sha1x2_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .start_i(start_i),
        .load_o (load),
        .prep_o (prep),
        .run_o  (run),
        .last_o (last),
        .step_o (step)
    );

    sha1x2_sched u_sched (
        .clk_i  (clk_i),
        .load_i (load),
        .shift_i(run),
        .block_i(block_i),
        .tap_o  (tap)
    );

    sha1x2_prep u_prep (
        .b_i  (st_q.b),
        .c_i  (st_q.c),
        .d_i  (st_q.d),
        .e_i  (st_q.e),
        .w0_i (tap[0]),
        .w1_i (tap[1]),
        .w2_i (tap[2]),
        .sum_o(sum_prep)
    );

    sha1x2_round u_round (
        .step_i (step),
        .a_i    (st_q.a),
        .b_i    (st_q.b),
        .c_i    (st_q.c),
        .sum_i  (sum_q),
        .w3_i   (tap[3]),
        .w4_i   (tap[4]),
        .state_o(st_nx),
        .sum_o  (sum_nx)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= '0;
            hin_q  <= '0;
            sum_q  <= '0;
            dig_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last;
            if (load) begin
                st_q  <= state_t'(chain_i);
                hin_q <= state_t'(chain_i);
            end else if (prep) begin
                sum_q <= sum_prep;
            end else if (run) begin
                st_q  <= st_nx;
                sum_q <= sum_nx;
            end
            if (last) begin
                dig_q.a <= hin_q.a + st_nx.a;
                dig_q.b <= hin_q.b + st_nx.b;
                dig_q.c <= hin_q.c + st_nx.c;
                dig_q.d <= hin_q.d + st_nx.d;
                dig_q.e <= hin_q.e + st_nx.e;
            end
        end
    end

    assign digest_o = dig_q;

endmodule

// File: rtl/sha1x2_core_chk.sv
module sha1x2_core_chk
    import sha1x2_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               start_i,
    input logic [STATE_W-1:0] digest_o,
    input logic               done_o
);

    localparam int AGE_W = $clog2(LATENCY + 1);

    // cycles since an accepted start; zero means idle
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                                    age_q <= '0;
        else if (age_q == '0 && start_i)              age_q <= AGE_W'(1);
        else if (age_q == AGE_W'(LATENCY))            age_q <= '0;
        else if (age_q != '0)                         age_q <= age_q + 1'b1;
    end

    // R4: the block completes 41 cycles after the start is taken
    p_done_latency_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q == AGE_W'(LATENCY)) |=> done_o);

    // R6: no completion other than the one owed to an accepted start
    p_done_owed_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ($past(age_q) == AGE_W'(LATENCY)));

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R7: the digest moves only together with done
    p_digest_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> $stable(digest_o));

endmodule

bind sha1x2_core sha1x2_core_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .digest_o(digest_o),
    .done_o  (done_o)
);

// File: tb/sha1x2_core_bench.sv
`timescale 1ns/1ps
module sha1x2_core_bench;

    localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [511:0] block = '0;
    logic [159:0] chain = '0;
    logic [159:0] digest;
    logic         done;

    int checks = 0;
    int errors = 0;
    logic [159:0] last_digest = '0;

    always #10 clk = ~clk;

    sha1x2_core u_sha1x2_core (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .block_i (block),
        .chain_i (chain),
        .digest_o(digest),
        .done_o  (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    // plain one-step-per-iteration compression model
    function automatic logic [159:0] ref_sha1(input logic [511:0] blk, input logic [159:0] h);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        {a, b, c, d, e} = h;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    // drives one block; optional start pulses at two mid-run cycles
    task automatic run_block(input logic [511:0] blk, input logic [159:0] h,
                             input int glitch_a, input int glitch_b,
                             output logic [159:0] dig);
        int  lat;
        bit  held;
        block = blk; chain = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        held = 1'b1;
        while (!done && lat < 100) begin
            if (digest !== last_digest) held = 1'b0;
            if (lat == glitch_a || lat == glitch_b) begin
                start = 1'b1; block = ~blk; chain = ~h;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == 41, "R4", "cycles from start to done", 160'(lat), 160'd41);
        check(held, "R7", "digest steady while busy", digest, last_digest);
        dig = digest;
        last_digest = digest;
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1", "done after reset", 160'(done), 160'd0);
        check(digest == '0, "R1", "digest after reset", digest, 160'd0);
    endtask

    task automatic t_abc();
        logic [159:0] d;
        run_block({32'h61626380, 416'd0, 64'h18}, IV, -1, -1, d);
        check(d == 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d, "R2", "abc digest",
              d, 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d);
    endtask

    task automatic t_two_block();
        logic [159:0] d1, d2;
        logic [511:0] b1, b2;
        b1 = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
              32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
              32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
              32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
        b2 = {480'd0, 32'h000001c0};
        run_block(b1, IV, -1, -1, d1);
        repeat (3) @(negedge clk);
        run_block(b2, d1, -1, -1, d2);
        check(d2 == 160'h84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1, "R3", "two-block digest",
              d2, 160'h84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1);
    endtask

    task automatic t_random();
        for (int n = 0; n < 6; n++) begin
            logic [511:0] b;
            logic [159:0] h, d;
            for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
            for (int i = 0; i < 5; i++) h[32*i +: 32] = $urandom;
            if (n == 0) b = '1;
            if (n == 1) h = '1;
            run_block(b, h, -1, -1, d);
            check(d == ref_sha1(b, h), "R8", "random block digest", d, ref_sha1(b, h));
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_ignore_start();
        logic [511:0] b;
        logic [159:0] d;
        bit quiet, held;
        for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
        run_block(b, IV, 5, 40, d);
        check(d == ref_sha1(b, IV), "R6", "digest with mid-run starts", d, ref_sha1(b, IV));
        quiet = 1'b1; held = 1'b1;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (done) quiet = 1'b0;
            if (digest !== d) held = 1'b0;
        end
        check(quiet, "R6", "no extra done after ignored starts", 160'(!quiet), 160'd0);
        check(quiet, "R5", "done is a single pulse", 160'(!quiet), 160'd0);
        check(held, "R7", "digest held while idle", digest, d);
    endtask

    task automatic t_back_to_back();
        logic [511:0] b1, b2;
        logic [159:0] d1, d2;
        for (int i = 0; i < 16; i++) begin
            b1[32*i +: 32] = $urandom;
            b2[32*i +: 32] = $urandom;
        end
        run_block(b1, IV, -1, -1, d1);
        run_block(b2, d1, -1, -1, d2);
        check(d1 == ref_sha1(b1, IV), "R9", "first of back-to-back pair", d1, ref_sha1(b1, IV));
        check(d2 == ref_sha1(b2, d1), "R9", "second of back-to-back pair", d2, ref_sha1(b2, d1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_abc();
        repeat (2) @(negedge clk);
        t_two_block();
        repeat (2) @(negedge clk);
        t_random();
        t_ignore_start();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule